// File: doc/BRIEF.md
# Raster Interrupt Generator

This block derives the periodic processor interrupt of a video subsystem from the horizontal and vertical sync outputs of a display timing controller. A 6-bit line counter advances once for each scan line, on the falling edge of horizontal sync. Each time it completes a period of 52 lines it requests an interrupt and starts again. Because 52 does not divide the frame height, the counter's phase is brought back into line once per frame, while vertical sync is active. This realignment raises an interrupt only when the line count is low enough that the previous interrupt is not too recent.

The request output stays active for a fixed number of fast-clock cycles, about 1.4 µs at 16 MHz, and then releases. Two strobes from the processor side act on the counter. The acknowledge strobe clears the counter's top bit. This gives the next period at least 32 lines of distance after an interrupt taken late. The clear strobe comes from the mode/control register write and zeroes the counter. All inputs are taken to be synchronous to the block clock.

Top module: `raster_irq_gen`

## Requirements
- R1: The line counter advances by exactly one for each high-to-low transition of `hsync_i`. The transition is found by comparing `hsync_i` with its value one clock earlier, so the width of the high phase has no effect on the count.
- R2: When an advance would make the count equal to 52 (`PERIOD`), the counter returns to 0 and an interrupt fires. Without other events, interrupts are therefore exactly 52 lines apart.
- R3: While `vsync_i` is high, the second falling edge of `hsync_i` seen since `vsync_i` rose realigns the counter to 0. This happens once per vertical sync pulse. Any cycle with `vsync_i` low restarts the edge tally for this rule.
- R4: At a realignment, an interrupt fires if the advanced count is below 32 (`QUIET_MIN`): a value of 31 fires and a value of 32 does not. At 32 or above the counter clears silently.
- R5: An interrupt is visible on `irq_o` from the clock edge that detects the triggering falling edge and lasts exactly 22 (`HOLD`) cycles, after which `irq_o` returns low.
- R6: A one-cycle pulse on `cnt_clr_i` zeroes the line counter. If the pulse coincides with a falling edge of `hsync_i`, that edge is not counted and fires nothing.
- R7: A one-cycle pulse on `ack_i` clears bit 5 (`ACK_BIT`) of the line counter and leaves the other bits unchanged. It has no effect when that bit is already 0. If it coincides with a counted edge, the bit is cleared before the advance.
- R8: An interrupt that fires while `irq_o` is still active restarts the hold time. `irq_o` stays high without a gap until `HOLD` cycles after the later event.
- R9: After reset the line counter is 0, the vertical-sync edge tally is 0, the sampled sync is low and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (the fast pixel-rate clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync from the display timing controller |
| vsync_i | input | 1 | Vertical sync from the display timing controller |
| ack_i | input | 1 | One-cycle interrupt acknowledge strobe from the processor |
| cnt_clr_i | input | 1 | One-cycle line-counter clear strobe from the control register |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: a 52-line period, the silent-realignment threshold at 32, bit 5 cleared by acknowledge, alignment on the second line of vertical sync and a 22-cycle hold. Sync lines in the bench last only six clocks. A full period therefore takes a few hundred cycles, and lines can be packed tightly enough that a realignment interrupt lands inside a running hold. This reaches the restart case of R8 as well as the 31/32 boundary of R4. Every pulse is compared on its exact rise and release cycle against a line-accurate reference model.

// File: rtl/raster_irq_pkg.sv
`timescale 1ns/1ps
package raster_irq_pkg;

    localparam int RIG_CNT_W     = 6;
    localparam int RIG_PERIOD    = 52;
    localparam int RIG_QUIET_MIN = 32;
    localparam int RIG_ACK_BIT   = 5;
    localparam int RIG_VS_LINES  = 2;
    localparam int RIG_HOLD      = 22;

    // What the line counter did in a given cycle
    typedef enum logic [2:0] {
        LEV_IDLE,
        LEV_STEP,
        LEV_PERIOD,
        LEV_ALIGN_FIRE,
        LEV_ALIGN_QUIET,
        LEV_CLEAR
    } line_ev_e;

endpackage

// File: rtl/rig_hsync_edge.sv
`timescale 1ns/1ps
module rig_hsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_i,
    output logic fall_o
);
    typedef struct packed {
        logic hs;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.hs = hsync_i;
        fall_o  = st_q.hs & ~hsync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rig_vsync_align.sv
`timescale 1ns/1ps
module rig_vsync_align #(
    parameter int VS_LINES = raster_irq_pkg::RIG_VS_LINES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    input  logic fall_i,
    output logic align_o
);
    localparam int VW = $clog2(VS_LINES + 1);

    typedef struct packed {
        logic [VW-1:0] seen;
    } vs_st_t;

    vs_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        align_o = vsync_i && fall_i && (st_q.seen == VW'(VS_LINES - 1));
        if (!vsync_i)
            st_d.seen = '0;
        else if (fall_i && (st_q.seen < VW'(VS_LINES)))
            st_d.seen = st_q.seen + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rig_line_divider.sv
`timescale 1ns/1ps
module rig_line_divider
    import raster_irq_pkg::*;
#(
    parameter int CNT_W     = RIG_CNT_W,
    parameter int PERIOD    = RIG_PERIOD,
    parameter int QUIET_MIN = RIG_QUIET_MIN,
    parameter int ACK_BIT   = RIG_ACK_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             align_i,
    input  logic             ack_i,
    input  logic             clr_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt;
    line_ev_e         ev;

    always_comb begin
        base = st_q.cnt;
        if (ack_i) base[ACK_BIT] = 1'b0;
        nxt      = base + 1'b1;
        st_d.cnt = base;
        ev       = LEV_IDLE;
        if (clr_i) begin
            st_d.cnt = '0;
            ev       = LEV_CLEAR;
        end else if (fall_i) begin
            if (align_i) begin
                st_d.cnt = '0;
                ev = (nxt < CNT_W'(QUIET_MIN)) ? LEV_ALIGN_FIRE : LEV_ALIGN_QUIET;
            end else if (nxt == CNT_W'(PERIOD)) begin
                st_d.cnt = '0;
                ev       = LEV_PERIOD;
            end else begin
                st_d.cnt = nxt;
                ev       = LEV_STEP;
            end
        end
        fire_o  = (ev == LEV_PERIOD) || (ev == LEV_ALIGN_FIRE);
        count_o = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rig_irq_stretch.sv
`timescale 1ns/1ps
module rig_irq_stretch #(
    parameter int HOLD = raster_irq_pkg::RIG_HOLD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic irq_o
);
    localparam int TW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [TW-1:0] left;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        if (fire_i)
            st_d.left = TW'(HOLD);
        else if (st_q.left != '0)
            st_d.left = st_q.left - 1'b1;
        else
            st_d.left = '0;
        irq_o = (st_q.left != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/raster_irq_gen.sv
`timescale 1ns/1ps
module raster_irq_gen
    import raster_irq_pkg::*;
#(
    parameter int CNT_W     = RIG_CNT_W,
    parameter int PERIOD    = RIG_PERIOD,
    parameter int QUIET_MIN = RIG_QUIET_MIN,
    parameter int ACK_BIT   = RIG_ACK_BIT,
    parameter int VS_LINES  = RIG_VS_LINES,
    parameter int HOLD      = RIG_HOLD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_i,
    input  logic vsync_i,
    input  logic ack_i,
    input  logic cnt_clr_i,
    output logic irq_o
);
    logic             hs_fall;
    logic             vs_align;
    logic             line_fire;
    logic [CNT_W-1:0] line_cnt;

    rig_hsync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync_i (hsync_i),
        .fall_o  (hs_fall)
    );

    rig_vsync_align #(.VS_LINES(VS_LINES)) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync_i (vsync_i),
        .fall_i  (hs_fall),
        .align_o (vs_align)
    );

    rig_line_divider #(
        .CNT_W     (CNT_W),
        .PERIOD    (PERIOD),
        .QUIET_MIN (QUIET_MIN),
        .ACK_BIT   (ACK_BIT)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (hs_fall),
        .align_i (vs_align),
        .ack_i   (ack_i),
        .clr_i   (cnt_clr_i),
        .fire_o  (line_fire),
        .count_o (line_cnt)
    );

    rig_irq_stretch #(.HOLD(HOLD)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (line_fire),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/raster_irq_chk.sv
`timescale 1ns/1ps
module raster_irq_chk #(
    parameter int CNT_W   = 6,
    parameter int PERIOD  = 52,
    parameter int ACK_BIT = 5,
    parameter int HOLD    = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             cnt_clr_i,
    input logic             hs_fall,
    input logic             vs_align,
    input logic             line_fire,
    input logic [CNT_W-1:0] line_cnt,
    input logic             irq_o
);
    localparam int SW = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] ACK_MASK = CNT_W'(1) << ACK_BIT;

    logic [SW-1:0] since_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     since_fire <= SW'(HOLD);
        else if (line_fire)             since_fire <= '0;
        else if (since_fire < SW'(HOLD)) since_fire <= since_fire + 1'b1;
    end

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_fall && !vs_align && !cnt_clr_i && !ack_i && line_cnt != CNT_W'(PERIOD - 1))
        |=> line_cnt == $past(line_cnt) + 1'b1);

    a_r1_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fall && !cnt_clr_i && !ack_i) |=> $stable(line_cnt));

    a_r2_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt < CNT_W'(PERIOD));

    a_r3_align_zero: assert property (@(posedge clk) disable iff (!rst_n)
        vs_align |=> line_cnt == '0);

    a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(line_fire));

    a_r5_span_high: assert property (@(posedge clk) disable iff (!rst_n)
        (since_fire < SW'(HOLD)) |-> irq_o);

    a_r5_span_low: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (since_fire < SW'(HOLD)));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_i |=> line_cnt == '0);

    a_r7_ack_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !hs_fall && !cnt_clr_i) |=> line_cnt == ($past(line_cnt) & ~ACK_MASK));

    a_r8_fire_loads: assert property (@(posedge clk) disable iff (!rst_n)
        line_fire |=> irq_o);
endmodule

bind raster_irq_gen raster_irq_chk #(
    .CNT_W   (CNT_W),
    .PERIOD  (PERIOD),
    .ACK_BIT (ACK_BIT),
    .HOLD    (HOLD)
) u_raster_irq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (ack_i),
    .cnt_clr_i (cnt_clr_i),
    .hs_fall   (hs_fall),
    .vs_align  (vs_align),
    .line_fire (line_fire),
    .line_cnt  (line_cnt),
    .irq_o     (irq_o)
);

// File: tb/test_raster_irq_gen.sv
`timescale 1ns/1ps
module test_raster_irq_gen;
    localparam int PERIOD    = 52;
    localparam int QUIET_MIN = 32;
    localparam int ACK_BIT   = 5;
    localparam int VS_LINES  = 2;
    localparam int HOLD      = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync = 1'b0, vsync = 1'b0, ack = 1'b0, clr = 1'b0;
    logic irq;

    always #5 clk = ~clk;

    raster_irq_gen #(
        .PERIOD(PERIOD), .QUIET_MIN(QUIET_MIN), .ACK_BIT(ACK_BIT),
        .VS_LINES(VS_LINES), .HOLD(HOLD)
    ) i_raster_irq_gen (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
        .ack_i(ack), .cnt_clr_i(clr), .irq_o(irq)
    );

    int    cyc = 0;
    int    n_chk = 0, n_bad = 0;
    int    n_pulse = 0, mark = 0;
    string cur_req = "R9";
    int    rise_q[$];
    int    end_q[$];
    int    m_cnt = 0, m_vsc = 0;
    bit    m_hs = 1'b0;
    bit    vs_lvl = 1'b0;
    bit    prev_irq = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of inputs and predicts the outcome
    task automatic tick(bit hs, bit a, bit c);
        bit fall;
        bit fire;
        int base;
        int nxt;
        int f;
        fire  = 1'b0;
        hsync = hs; vsync = vs_lvl; ack = a; clr = c;
        fall  = m_hs && !hs;
        m_hs  = hs;
        base  = m_cnt;
        if (a) base = base & ~(1 << ACK_BIT);
        if (c) m_cnt = 0;
        else if (fall) begin
            nxt = base + 1;
            if (vs_lvl && m_vsc == VS_LINES - 1) begin
                fire  = (nxt < QUIET_MIN);
                m_cnt = 0;
            end else if (nxt == PERIOD) begin
                fire  = 1'b1;
                m_cnt = 0;
            end else m_cnt = nxt;
        end else m_cnt = base;
        if (!vs_lvl) m_vsc = 0;
        else if (fall && m_vsc < VS_LINES) m_vsc++;
        if (fire) begin
            f = cyc + 1;
            if (end_q.size() > 0 && f <= end_q[end_q.size()-1])
                end_q[end_q.size()-1] = f + HOLD;
            else begin
                rise_q.push_back(f);
                end_q.push_back(f + HOLD);
            end
        end
        @(negedge clk);
        ack = 1'b0; clr = 1'b0;
    endtask

    task automatic lines(int n);
        for (int i = 0; i < n; i++) begin
            tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0);
            tick(0, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    task automatic expect_pulses(int exp, string req);
        idle(HOLD + 3);
        check(n_pulse - mark == exp, req, "pulse count", n_pulse - mark, exp);
        mark = n_pulse;
    endtask

    // Monitor: pops expected pulses and compares rise and release cycles
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq && !prev_irq) begin
                if (rise_q.size() == 0) check(1'b0, cur_req, "unexpected rise at cycle", cyc, -1);
                else check(cyc == rise_q[0], cur_req, "rise cycle", cyc, rise_q[0]);
            end
            if (!irq && prev_irq) begin
                n_pulse++;
                if (end_q.size() == 0) check(1'b0, cur_req, "unexpected release at cycle", cyc, -1);
                else begin
                    check(cyc == end_q[0], cur_req, "release cycle", cyc, end_q[0]);
                    void'(rise_q.pop_front());
                    void'(end_q.pop_front());
                end
            end
            prev_irq = irq;
        end
    end

    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R9", "irq during reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq == 1'b0, "R9", "irq after reset", int'(irq), 0);
        idle(4);
        check(irq == 1'b0, "R9", "irq idle", int'(irq), 0);

        // R2 / R5: free-running period
        cur_req = "R2";
        lines(PERIOD - 1);
        expect_pulses(0, "R2");
        lines(1);
        expect_pulses(1, "R5");
        lines(2 * PERIOD);
        expect_pulses(2, "R2");

        // R1: width of the high phase does not matter
        cur_req = "R1";
        for (int i = 0; i < 40; i++) tick(1, 0, 0);
        tick(0, 0, 0);
        for (int i = 0; i < 7; i++) tick(1, 0, 0);
        tick(0, 0, 0);
        lines(PERIOD - 3);
        expect_pulses(0, "R1");
        lines(1);
        expect_pulses(1, "R1");

        // R6: clear strobe, alone and on a falling edge
        cur_req = "R6";
        lines(30);
        tick(0, 0, 1);
        lines(PERIOD - 1);
        expect_pulses(0, "R6");
        lines(1);
        expect_pulses(1, "R6");
        lines(20);
        tick(1, 0, 0); tick(1, 0, 0);
        tick(0, 0, 1);
        lines(PERIOD - 1);
        expect_pulses(0, "R6");
        lines(1);
        expect_pulses(1, "R6");

        // R7: acknowledge clears bit 5
        cur_req = "R7";
        lines(40);
        tick(0, 1, 0);
        lines(43);
        expect_pulses(0, "R7");
        lines(1);
        expect_pulses(1, "R7");
        lines(10);
        tick(0, 1, 0);
        lines(41);
        expect_pulses(0, "R7");
        lines(1);
        expect_pulses(1, "R7");
        lines(45);
        tick(1, 0, 0); tick(1, 0, 0);
        tick(0, 1, 0);
        lines(37);
        expect_pulses(0, "R7");
        lines(1);
        expect_pulses(1, "R7");

        // R3 / R4: realignment inside vertical sync
        cur_req = "R3";
        lines(10);
        vs_lvl = 1'b1;
        lines(1);
        expect_pulses(0, "R3");
        lines(1);
        expect_pulses(1, "R3");
        lines(5);
        expect_pulses(0, "R3");
        vs_lvl = 1'b0;
        idle(2);
        cur_req = "R4";
        lines(35);
        vs_lvl = 1'b1;
        lines(2);
        vs_lvl = 1'b0;
        expect_pulses(0, "R4");
        lines(PERIOD - 1);
        expect_pulses(0, "R4");
        lines(1);
        expect_pulses(1, "R4");
        lines(29);
        vs_lvl = 1'b1;
        lines(2);
        vs_lvl = 1'b0;
        expect_pulses(1, "R4");
        lines(30);
        vs_lvl = 1'b1;
        lines(2);
        vs_lvl = 1'b0;
        expect_pulses(0, "R4");
        cur_req = "R3";
        vs_lvl = 1'b1;
        lines(1);
        vs_lvl = 1'b0;
        idle(1);
        vs_lvl = 1'b1;
        lines(1);
        expect_pulses(0, "R3");
        lines(1);
        expect_pulses(1, "R3");
        vs_lvl = 1'b0;
        idle(2);

        // R8: realignment inside a running hold restarts it
        cur_req = "R8";
        lines(PERIOD);
        vs_lvl = 1'b1;
        tick(1, 0, 0); tick(0, 0, 0);
        tick(1, 0, 0); tick(0, 0, 0);
        vs_lvl = 1'b0;
        expect_pulses(1, "R8");

        idle(HOLD + 4);
        check(rise_q.size() == 0, "R5", "outstanding pulses", rise_q.size(), 0);
        check(irq == 1'b0, "R5", "irq at end", int'(irq), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule